// File: doc/BRIEF.md
# Interrupt Pin Latch and Dispatcher

This block watches 24 interrupt request lines and keeps one pending bit per line. A 64-bit configuration entry for each line is presented on a flat input bus. Each entry chooses edge or level behaviour for its line, can mask the line, and supplies the routing fields copied into the outgoing message. When a line asserts, or when the configuration owner pulses a table-changed strobe, a service scan walks the lines from index 0 upward. For every pending, unmasked line it emits one delivery message to the processor interrupt bus over a valid/ready handshake.

Each message carries the destination, destination mode, delivery mode, vector, polarity and trigger mode of the selected line. An edge line's pending bit is consumed when its message is accepted. A level line stays pending while its input is high, so later scans deliver it again. A scan request that arrives during a scan is held, and one further full scan runs after the current one ends.

Top module: `irq_dispatch`

## Requirements
- R1: Reset clears every pending bit, the stored previous line values and any scan in progress. `msg_valid` is 0 during reset and after it. A line that went pending before reset produces no message afterwards.
- R2: Entry fields are laid out as follows. Vector is bits 7:0, delivery mode is bits 10:8 and destination mode is bit 11. Polarity is bit 13 and trigger mode is bit 15 (1 = level, 0 = edge). Mask is bit 16 (1 = masked) and destination is bits 63:56. A message copies these fields unchanged from the entry of the line it serves.
- R3: When the delivery mode is 3'b111, the message vector is 8'hFF, whatever the entry's vector field holds.
- R4: A masked line is skipped by the scan and produces no message, but its pending bit is kept. Once the line is unmasked, a table-changed pulse delivers it.
- R5: An edge line becomes pending on a 0-to-1 transition of its input. Deasserting the input has no effect. Acceptance of its message clears the pending bit, so a later scan does not deliver it again while the input stays high.
- R6: A level line's pending bit follows its input, delayed by one register. Acceptance does not clear it, so every scan delivers it again while the input is high. Once the input is low, no further message is sent.
- R7: A scan starts on any line's 0-to-1 transition or on a `tbl_changed` pulse. It visits lines in ascending index order and sends exactly one message per pending, unmasked line.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and all message fields hold their values.
- R9: A scan trigger that arrives while a scan is running causes one more complete scan from line 0 after the current scan finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 24 | Interrupt request lines, active high |
| tbl_flat | input | 1536 | Configuration entries; entry i is bits 64*i+63 down to 64*i |
| tbl_changed | input | 1 | One-cycle pulse after any entry was rewritten |
| msg_valid | output | 1 | Delivery message is valid |
| msg_ready | input | 1 | Interrupt bus accepts the message |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination mode |
| msg_del_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector (8'hFF for delivery mode 3'b111) |
| msg_polarity | output | 1 | Polarity |
| msg_trigger | output | 1 | Trigger mode (1 = level) |

## Verification
The hardest situation to reach from the ports is a new trigger landing mid-scan on a line the scan has already passed. The line would then be missed without the rescan. The bench reaches it by holding `msg_ready` low so the scan stalls on a level line at index 8. It then raises an edge line at index 1 and releases `msg_ready`. The accepted sequence must be index 8, then 1, then 8 again.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  localparam int ENTRY_W      = 64;
  localparam int VEC_LSB      = 0;
  localparam int DELM_LSB     = 8;
  localparam int DSTM_BIT     = 11;
  localparam int POL_BIT      = 13;
  localparam int TRIG_BIT     = 15;
  localparam int MASK_BIT     = 16;
  localparam int DEST_LSB     = 56;
  localparam logic [2:0] DELM_EXTINT = 3'b111;
  localparam logic [7:0] EXTINT_VEC  = 8'hFF;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] del_mode;
    logic [7:0] vector;
    logic       polarity;
    logic       trigger;
  } irq_msg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_SEND  = 2'd2
  } scan_state_t;

  function automatic irq_msg_t entry_to_msg(input logic [ENTRY_W-1:0] e);
    irq_msg_t m;
    m.dest      = e[DEST_LSB +: 8];
    m.dest_mode = e[DSTM_BIT];
    m.del_mode  = e[DELM_LSB +: 3];
    m.vector    = (e[DELM_LSB +: 3] == DELM_EXTINT) ? EXTINT_VEC : e[VEC_LSB +: 8];
    m.polarity  = e[POL_BIT];
    m.trigger   = e[TRIG_BIT];
    return m;
  endfunction

endpackage

// File: rtl/irqd_pin_latch.sv
module irqd_pin_latch #(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] line_in,
  input  logic [NPINS-1:0] level_sel,
  input  logic             clr_req,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [NPINS-1:0] pending,
  output logic             rise_any
);

  logic [NPINS-1:0] line_q;
  logic [NPINS-1:0] rise;
  logic [NPINS-1:0] pend_d;

  assign rise     = line_in & ~line_q;
  assign rise_any = |rise;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic hit;
    assign hit = clr_req && (clr_idx == IDX_W'(g));
    always_comb begin
      if (level_sel[g]) pend_d[g] = line_in[g];
      else              pend_d[g] = rise[g] | (pending[g] & ~hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      pending <= '0;
    end else begin
      line_q  <= line_in;
      pending <= pend_d;
    end
  end

  // R6: a level line's pending bit mirrors its input one cycle later
  p_level_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pending ^ $past(line_in)) & $past(level_sel)) == '0));

  // R5: accepting an edge line's message consumes its pending bit
  p_edge_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !level_sel[clr_idx] && !rise[clr_idx]) |=> !pending[$past(clr_idx)]);

endmodule

// File: rtl/irqd_scan_ctrl.sv
module irqd_scan_ctrl
  import irqd_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic [NPINS-1:0] eligible,
  input  logic             out_ready,
  output logic [IDX_W-1:0] cur_idx,
  output logic             capture,
  output logic             accept,
  output logic             out_valid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPINS - 1);

  scan_state_t      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             rerun_q, rerun_d;
  logic             advance, rerun_set;

  assign cur_idx   = idx_q;
  assign out_valid = (state_q == ST_SEND);
  assign capture   = (state_q == ST_PROBE) && eligible[idx_q];
  assign accept    = (state_q == ST_SEND) && out_ready;
  assign advance   = ((state_q == ST_PROBE) && !eligible[idx_q]) || accept;
  assign rerun_set = rerun_q | kick;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rerun_d = rerun_q;
    case (state_q)
      ST_IDLE: begin
        if (kick) begin
          state_d = ST_PROBE;
          idx_d   = '0;
          rerun_d = 1'b0;
        end
      end
      default: begin
        if (capture) begin
          state_d = ST_SEND;
          rerun_d = rerun_set;
        end else if (advance) begin
          if (idx_q == LAST_IDX) begin
            idx_d   = '0;
            rerun_d = 1'b0;
            state_d = rerun_set ? ST_PROBE : ST_IDLE;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            rerun_d = rerun_set;
            state_d = ST_PROBE;
          end
        end else begin
          rerun_d = rerun_set;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rerun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rerun_q <= rerun_d;
    end
  end

  // R7: the scan pointer only steps up by one or wraps to zero
  p_scan_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> ((idx_q == $past(idx_q) + IDX_W'(1)) || (idx_q == '0)));

  // R9: a trigger during a scan is remembered or restarts at zero
  p_rerun_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && state_q != ST_IDLE) |=> (rerun_q || (state_q == ST_PROBE && idx_q == '0)));

endmodule

// File: rtl/irqd_msg_reg.sv
module irqd_msg_reg
  import irqd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [ENTRY_W-1:0] entry,
  input  logic               out_valid,
  input  logic               out_ready,
  output irq_msg_t           msg
);

  irq_msg_t msg_q, msg_d;

  assign msg_d = capture ? entry_to_msg(entry) : msg_q;
  assign msg   = msg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msg_q <= '0;
    else        msg_q <= msg_d;
  end

  // R8: a stalled message keeps valid and every field
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(msg_q)));

  // R3: external-interrupt delivery always shows the all-ones vector
  p_extint_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && msg_q.del_mode == DELM_EXTINT) |-> (msg_q.vector == EXTINT_VEC));

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NPINS = 24,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         irq_in,
  input  logic [NPINS*ENTRY_W-1:0] tbl_flat,
  input  logic                     tbl_changed,
  output logic                     msg_valid,
  input  logic                     msg_ready,
  output logic [7:0]               msg_dest,
  output logic                     msg_dest_mode,
  output logic [2:0]               msg_del_mode,
  output logic [7:0]               msg_vector,
  output logic                     msg_polarity,
  output logic                     msg_trigger
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [ENTRY_W-1:0] ent_arr [NPINS];
  logic [NPINS-1:0]   level_sel, mask_sel, pending, eligible;
  logic               unused_tbl;

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    assign ent_arr[g]   = tbl_flat[g*ENTRY_W +: ENTRY_W];
    assign level_sel[g] = ent_arr[g][TRIG_BIT];
    assign mask_sel[g]  = ent_arr[g][MASK_BIT];
  end
  assign unused_tbl = ^tbl_flat;

  logic             rise_any, kick, capture, accept;
  logic [IDX_W-1:0] cur_idx;
  irq_msg_t         msg;

  assign kick     = rise_any | tbl_changed;
  assign eligible = pending & ~mask_sel;

  irqd_pin_latch #(.NPINS(NPINS)) u_latch (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .line_in   (irq_in),
    .level_sel (level_sel),
    .clr_req   (accept),
    .clr_idx   (cur_idx),
    .pending   (pending),
    .rise_any  (rise_any)
  );

  irqd_scan_ctrl #(.NPINS(NPINS)) u_scan (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .kick      (kick),
    .eligible  (eligible),
    .out_ready (msg_ready),
    .cur_idx   (cur_idx),
    .capture   (capture),
    .accept    (accept),
    .out_valid (msg_valid)
  );

  irqd_msg_reg u_msg (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .capture   (capture),
    .entry     (ent_arr[cur_idx]),
    .out_valid (msg_valid),
    .out_ready (msg_ready),
    .msg       (msg)
  );

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_del_mode  = msg.del_mode;
  assign msg_vector    = msg.vector;
  assign msg_polarity  = msg.polarity;
  assign msg_trigger   = msg.trigger;

  // R1: no message is offered while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    (!rst_i_n) |-> !msg_valid);

endmodule

// File: tb/irq_dispatch_bench.sv
module irq_dispatch_bench;

  localparam int NP = 24;
  localparam logic [63:0] MASKED = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic [4:0]  pin;
    logic [63:0] ent;
    logic [1:0]  n;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'd0,  64'h0500_0000_0000_0031, 2'd1},
    '{5'd23, 64'h1200_0000_0000_0740, 2'd1},
    '{5'd5,  64'h0300_0000_0001_0055, 2'd0},
    '{5'd7,  64'h0F00_0000_0000_A877, 2'd1},
    '{5'd12, 64'hA000_0000_0000_0422, 2'd1},
    '{5'd19, 64'h0100_0000_0001_8066, 2'd0},
    '{5'd2,  64'hFF00_0000_0000_2110, 2'd1},
    '{5'd9,  64'h0400_0000_0001_0799, 2'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     irq_in;
  logic [63:0]       ent [NP];
  logic [NP*64-1:0]  tbl_flat;
  logic              tbl_changed;
  logic              msg_valid, msg_ready;
  logic [7:0]        msg_dest, msg_vector;
  logic              msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0]        msg_del_mode;

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  logic [21:0] cap_msg [256];

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) tbl_flat[i*64 +: 64] = ent[i];
  end

  irq_dispatch u_irq_dispatch (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .tbl_flat(tbl_flat),
    .tbl_changed(tbl_changed), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode), .msg_del_mode(msg_del_mode),
    .msg_vector(msg_vector), .msg_polarity(msg_polarity), .msg_trigger(msg_trigger)
  );

  // handshake monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      cap_msg[cap_n[7:0]] = {msg_dest, msg_dest_mode, msg_del_mode, msg_vector,
                             msg_polarity, msg_trigger};
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [21:0] exp_msg(input logic [63:0] e);
    logic [7:0] v;
    v = (e[10:8] == 3'b111) ? 8'hFF : e[7:0];
    return {e[63:56], e[11], e[10:8], v, e[13], e[15]};
  endfunction

  function automatic logic [7:0] vec_of(input logic [21:0] m);
    return m[9:2];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic kick_tbl();
    tbl_changed = 1'b1;
    tick(1);
    tbl_changed = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_in = '0;
    tbl_changed = 1'b0;
    msg_ready = 1'b1;
    for (int i = 0; i < NP; i++) ent[i] = MASKED;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    rst_n = 1'b0;
    irq_in = '0;
    tbl_changed = 1'b0;
    msg_ready = 1'b1;
    for (int i = 0; i < NP; i++) ent[i] = MASKED;
    tick(3);
    chk("R1 valid low in reset", 32'(msg_valid), 32'd0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 valid low after reset", 32'(msg_valid), 32'd0);

    // vector table: one line at a time
    for (int v = 0; v < 8; v++) begin
      do_reset();
      ent[VECS[v].pin] = VECS[v].ent;
      kick_tbl();
      tick(60);
      base = cap_n;
      irq_in[VECS[v].pin] = 1'b1;
      tick(40);
      irq_in[VECS[v].pin] = 1'b0;
      tick(40);
      if (VECS[v].n == 2'd0)
        chk("R4 masked line sends nothing", 32'(cap_n - base), 32'd0);
      else begin
        chk("R7 one message per line", 32'(cap_n - base), 32'd1);
        if (VECS[v].ent[10:8] == 3'b111)
          chk("R3 extint vector", 32'(cap_msg[base[7:0]]), 32'(exp_msg(VECS[v].ent)));
        else
          chk("R2 message fields", 32'(cap_msg[base[7:0]]), 32'(exp_msg(VECS[v].ent)));
      end
    end

    // R7: ascending order with simultaneous edges
    do_reset();
    ent[3]  = 64'h0100_0000_0000_00A3;
    ent[10] = 64'h0100_0000_0000_00AA;
    ent[20] = 64'h0100_0000_0000_00B4;
    kick_tbl();
    tick(60);
    base = cap_n;
    irq_in[3] = 1'b1; irq_in[10] = 1'b1; irq_in[20] = 1'b1;
    tick(60);
    chk("R7 three messages", 32'(cap_n - base), 32'd3);
    chk("R7 first is line 3",   32'(vec_of(cap_msg[base[7:0]])),        32'h0A3);
    chk("R7 second is line 10", 32'(vec_of(cap_msg[8'(base + 1)])),     32'h0AA);
    chk("R7 third is line 20",  32'(vec_of(cap_msg[8'(base + 2)])),     32'h0B4);

    // R5: consumed edge lines stay quiet on rescans, even held high
    base = cap_n;
    kick_tbl();
    tick(60);
    chk("R5 edge not redelivered while held", 32'(cap_n - base), 32'd0);
    irq_in = '0;
    tick(2);
    kick_tbl();
    tick(60);
    chk("R5 edge deassert no effect", 32'(cap_n - base), 32'd0);

    // R4/R5: pending kept while masked and across deassertion
    do_reset();
    ent[6] = 64'h0200_0000_0001_0066;
    kick_tbl();
    tick(60);
    base = cap_n;
    irq_in[6] = 1'b1;
    tick(3);
    irq_in[6] = 1'b0;
    tick(60);
    chk("R4 masked edge holds back", 32'(cap_n - base), 32'd0);
    ent[6] = 64'h0200_0000_0000_0066;
    kick_tbl();
    tick(60);
    chk("R4 unmask delivers kept edge", 32'(cap_n - base), 32'd1);
    chk("R5 kept edge vector", 32'(vec_of(cap_msg[base[7:0]])), 32'h066);

    // R6: level line redelivered per scan until low
    do_reset();
    ent[4] = 64'h0200_0000_0000_8044;
    kick_tbl();
    tick(60);
    base = cap_n;
    irq_in[4] = 1'b1;
    tick(60);
    chk("R6 level first delivery", 32'(cap_n - base), 32'd1);
    kick_tbl();
    tick(60);
    chk("R6 level second delivery", 32'(cap_n - base), 32'd2);
    kick_tbl();
    tick(60);
    chk("R6 level third delivery", 32'(cap_n - base), 32'd3);
    irq_in[4] = 1'b0;
    tick(3);
    kick_tbl();
    tick(60);
    chk("R6 low level not delivered", 32'(cap_n - base), 32'd3);

    // R8 stall then R9 rescan
    do_reset();
    ent[8] = 64'h0300_0000_0000_8088;
    ent[1] = 64'h0300_0000_0000_0011;
    kick_tbl();
    tick(60);
    base = cap_n;
    msg_ready = 1'b0;
    irq_in[8] = 1'b1;
    tick(40);
    chk("R8 valid held under stall", 32'(msg_valid), 32'd1);
    chk("R8 vector held under stall", 32'(msg_vector), 32'h088);
    irq_in[1] = 1'b1;
    tick(10);
    chk("R8 still valid, nothing accepted", 32'({msg_valid, 8'(cap_n - base)}), 32'h100);
    msg_ready = 1'b1;
    tick(80);
    chk("R9 rescan message count", 32'(cap_n - base), 32'd3);
    chk("R9 first line 8",  32'(vec_of(cap_msg[base[7:0]])),    32'h088);
    chk("R9 then line 1",   32'(vec_of(cap_msg[8'(base + 1)])), 32'h011);
    chk("R9 then line 8",   32'(vec_of(cap_msg[8'(base + 2)])), 32'h088);

    // R1: reset discards a pending line
    do_reset();
    ent[14] = 64'h0200_0000_0001_00E1;
    kick_tbl();
    tick(10);
    irq_in[14] = 1'b1;
    tick(3);
    irq_in[14] = 1'b0;
    tick(3);
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    base = cap_n;
    ent[14] = 64'h0200_0000_0000_00E1;
    kick_tbl();
    tick(60);
    chk("R1 pending cleared by reset", 32'(cap_n - base), 32'd0);

    summary();
    $finish;
  end

endmodule